// File: doc/BRIEF.md
# DRAM Refresh and Address-Multiplexing Controller

This block connects a simple processor request port to an asynchronous DRAM array. Each request carries a flat word address. The block splits that address into a row part (upper bits) and a column part (lower bits). It then presents the two parts one after the other on a shared, narrower address bus. The row-address strobe latches the row part and the column-address strobe latches the column part. Writes drive the data bus and the active-low write enable while the column strobe is low. Reads capture the array's data on the last column cycle and return it with a one-cycle ready pulse.

DRAM cells lose their charge, so an interval timer raises a refresh request every `REFRESH_CYCLES` clocks. For 256 rows in 4 ms the interval is 15.6 µs, which is 3120 clocks at 200 MHz. The controller serves each request with a refresh that asserts only the row strobe, using the row held in an internal wrapping counter. It fits these refreshes between processor accesses without any action from the processor, which simply waits longer for ready. A request that arrives mid-access waits until that access ends. If refresh and a processor request are both waiting when the bus is free, refresh goes first. Every cycle of either kind ends with a precharge period during which the row strobe stays high. A sticky status flag reports a refresh request that was still unserved when the next one fell due.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While `rst` is high, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, and `dram_dq_oe`, `cpu_ready` and `ref_overrun` are 0.
- R2: An accepted access holds `dram_ras_n` low with the row part (`cpu_addr[ROW_W+COL_W-1:COL_W]`) on `dram_addr` for `T_RCD` cycles. It then keeps RAS low for `T_CAS` further cycles with `dram_cas_n` low and the column part (`cpu_addr[COL_W-1:0]`) on `dram_addr`.
- R3: During the column phase of a write, `dram_we_n` is 0, `dram_dq_oe` is 1 and `dram_dq_out` carries `cpu_wdata`. A read keeps `dram_we_n` at 1 and the bus undriven. `cpu_rdata` returns the value seen on `dram_dq_in` in the last column cycle, so a read returns the data last written to that address.
- R4: A refresh cycle holds `dram_ras_n` low for `T_RAS` cycles. During it `dram_cas_n` and `dram_we_n` stay at 1, `dram_dq_oe` stays at 0, and the refresh row is on `dram_addr`.
- R5: The refresh row starts at 0 after reset. It advances by one after each refresh and wraps from all ones to 0.
- R6: The interval timer raises a refresh request every `REFRESH_CYCLES` clocks. With no processor traffic, successive refreshes therefore start exactly `REFRESH_CYCLES` cycles apart.
- R7: A pending refresh waits for an access in progress to finish. When refresh and a processor request both wait on a free bus, the refresh runs first. A read issued as a refresh starts sees `cpu_ready` `T_RAS+T_RP+1+T_RCD+T_CAS` cycles later.
- R8: After every cycle of either kind, `dram_ras_n` stays high for at least `T_RP` cycles before it falls again.
- R9: `ref_overrun` rises when a new refresh request falls due while the previous one is still unserved, and it stays high until reset. It stays 0 when the interval covers the worst-case wait.
- R10: `cpu_ready` is a single-cycle pulse, issued one cycle after the last column cycle, and it stays 0 throughout refresh cycles. `cpu_req` must be held until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ROW_W+COL_W | Word address, row part in upper bits |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Write data toward the array |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | DATA_W | Read data from the array |
| ref_overrun | output | 1 | Sticky missed-refresh-deadline flag |

## Verification
An idle request is picked up on the next clock edge. The row phase then begins one cycle after the request is presented, the column phase `T_RCD` cycles after that, and `cpu_ready` with the read data one cycle after the last column cycle. A refresh begins on the cycle after the timer tick when the bus is free. The bench samples every output on the falling edge, half a cycle after the register that drives it changes. It compares each output in the same cycle against a behavioural model that counts the same intervals with integers. Directed checks then measure the refresh-start spacing and the read latency behind a refresh in whole cycles, and watch the refresh rows for step and wrap.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ROW  = 3'd1,
      ST_COL  = 3'd2,
      ST_REF  = 3'd3,
      ST_PRE  = 3'd4
   } dram_state_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int unsigned REFRESH_CYCLES = 3120
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_done,
   output logic ref_pending,
   output logic overrun
);
   localparam int unsigned TW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
   localparam logic [TW-1:0] LAST = TW'(REFRESH_CYCLES - 1);

   logic [TW-1:0] tcount;
   logic          tick;

   assign tick = (tcount == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         tcount      <= '0;
         ref_pending <= 1'b0;
         overrun     <= 1'b0;
      end else begin
         tcount      <= tick ? '0 : tcount + 1'b1;
         ref_pending <= tick | (ref_pending & ~ref_done);
         if (tick && ref_pending && !ref_done)
            overrun <= 1'b1;
      end
   end
endmodule

// File: rtl/dram_refresh_row_ctr.sv
module dram_refresh_row_ctr #(
   parameter int unsigned ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [ROW_W-1:0] row
);
   always_ff @(posedge clk) begin
      if (rst)
         row <= '0;
      else if (step)
         row <= row + 1'b1;
   end
endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
   import dram_ctl_pkg::*;
#(
   parameter int unsigned T_RCD = 2,
   parameter int unsigned T_CAS = 2,
   parameter int unsigned T_RAS = 3,
   parameter int unsigned T_RP  = 2
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        cpu_req,
   input  logic        ref_pending,
   output dram_state_e state,
   output logic        accept,
   output logic        access_done,
   output logic        ref_done
);
   localparam int unsigned T_MAX = max_of(max_of(T_RCD, T_CAS), max_of(T_RAS, T_RP));
   localparam int unsigned CW    = $clog2(T_MAX + 1);

   logic [CW-1:0] left;
   logic          last;

   assign last        = (left == '0);
   assign accept      = (state == ST_IDLE) && !ref_pending && cpu_req;
   assign access_done = (state == ST_COL) && last;
   assign ref_done    = (state == ST_REF) && last;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         left  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (ref_pending) begin
                  state <= ST_REF;
                  left  <= CW'(T_RAS - 1);
               end else if (cpu_req) begin
                  state <= ST_ROW;
                  left  <= CW'(T_RCD - 1);
               end
            end
            ST_ROW: begin
               if (last) begin
                  state <= ST_COL;
                  left  <= CW'(T_CAS - 1);
               end else begin
                  left <= left - 1'b1;
               end
            end
            ST_COL, ST_REF: begin
               if (last) begin
                  state <= ST_PRE;
                  left  <= CW'(T_RP - 1);
               end else begin
                  left <= left - 1'b1;
               end
            end
            ST_PRE: begin
               if (last)
                  state <= ST_IDLE;
               else
                  left <= left - 1'b1;
            end
            default: begin
               state <= ST_IDLE;
               left  <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
   import dram_ctl_pkg::*;
#(
   parameter int unsigned ROW_W          = 8,
   parameter int unsigned COL_W          = 8,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned REFRESH_CYCLES = 3120,
   parameter int unsigned T_RCD          = 2,
   parameter int unsigned T_CAS          = 2,
   parameter int unsigned T_RAS          = 3,
   parameter int unsigned T_RP           = 2,
   localparam int unsigned A_W           = ROW_W + COL_W,
   localparam int unsigned MA_W          = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [A_W-1:0]    cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [MA_W-1:0]   dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in,
   output logic              ref_overrun
);
   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("dram_refresh_ctrl: widths must be at least 1");
   end
   if (T_RCD < 1 || T_CAS < 1 || T_RAS < 1 || T_RP < 1) begin : g_bad_timing
      $error("dram_refresh_ctrl: timing counts must be at least 1");
   end
   if (REFRESH_CYCLES < 2) begin : g_bad_interval
      $error("dram_refresh_ctrl: refresh interval must be at least 2 cycles");
   end

   dram_state_e       state;
   logic              accept, access_done, ref_done, ref_pending;
   logic [ROW_W-1:0]  ref_row;
   logic [ROW_W-1:0]  lat_row;
   logic [COL_W-1:0]  lat_col;
   logic              lat_we;
   logic [DATA_W-1:0] lat_wdata;
   logic [MA_W-1:0]   row_bus, col_bus, ref_bus;

   dram_refresh_timer #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_timer (
      .clk         (clk),
      .rst         (rst),
      .ref_done    (ref_done),
      .ref_pending (ref_pending),
      .overrun     (ref_overrun)
   );

   dram_refresh_row_ctr #(.ROW_W(ROW_W)) u_row_ctr (
      .clk  (clk),
      .rst  (rst),
      .step (ref_done),
      .row  (ref_row)
   );

   dram_cycle_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .cpu_req     (cpu_req),
      .ref_pending (ref_pending),
      .state       (state),
      .accept      (accept),
      .access_done (access_done),
      .ref_done    (ref_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_row   <= '0;
         lat_col   <= '0;
         lat_we    <= 1'b0;
         lat_wdata <= '0;
         cpu_ready <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         if (accept) begin
            lat_row   <= cpu_addr[A_W-1:COL_W];
            lat_col   <= cpu_addr[COL_W-1:0];
            lat_we    <= cpu_we;
            lat_wdata <= cpu_wdata;
         end
         cpu_ready <= access_done;
         if (access_done)
            cpu_rdata <= dram_dq_in;
      end
   end

   if (ROW_W < MA_W) begin : g_row_pad
      assign row_bus = {{(MA_W-ROW_W){1'b0}}, lat_row};
      assign ref_bus = {{(MA_W-ROW_W){1'b0}}, ref_row};
   end else begin : g_row_full
      assign row_bus = lat_row;
      assign ref_bus = ref_row;
   end

   if (COL_W < MA_W) begin : g_col_pad
      assign col_bus = {{(MA_W-COL_W){1'b0}}, lat_col};
   end else begin : g_col_full
      assign col_bus = lat_col;
   end

   always_comb begin
      dram_addr  = '0;
      dram_ras_n = 1'b1;
      dram_cas_n = 1'b1;
      dram_we_n  = 1'b1;
      dram_dq_oe = 1'b0;
      unique case (state)
         ST_ROW: begin
            dram_addr  = row_bus;
            dram_ras_n = 1'b0;
         end
         ST_COL: begin
            dram_addr  = col_bus;
            dram_ras_n = 1'b0;
            dram_cas_n = 1'b0;
            dram_we_n  = ~lat_we;
            dram_dq_oe = lat_we;
         end
         ST_REF: begin
            dram_addr  = ref_bus;
            dram_ras_n = 1'b0;
         end
         default: ;
      endcase
   end

   assign dram_dq_out = lat_wdata;
endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
   parameter int unsigned ROW_W = 8,
   parameter int unsigned T_RP  = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             dram_ras_n,
   input logic             dram_cas_n,
   input logic             dram_we_n,
   input logic             dram_dq_oe,
   input logic             cpu_ready,
   input logic             ref_overrun,
   input logic [ROW_W-1:0] ref_row
);
   logic [31:0] high_cnt;

   always_ff @(posedge clk) begin
      if (rst)
         high_cnt <= T_RP;
      else if (!dram_ras_n)
         high_cnt <= '0;
      else if (high_cnt < T_RP + 1)
         high_cnt <= high_cnt + 1;
   end

   p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (rst)
      !dram_cas_n |-> !dram_ras_n);

   p_row_before_col_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(dram_cas_n) |-> $past(!dram_ras_n));

   p_we_needs_cas_r3: assert property (@(posedge clk) disable iff (rst)
      !dram_we_n |-> !dram_cas_n);

   p_oe_only_write_r3: assert property (@(posedge clk) disable iff (rst)
      dram_dq_oe |-> !dram_we_n);

   p_row_step_r5: assert property (@(posedge clk) disable iff (rst)
      (ref_row != $past(ref_row)) |-> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

   p_precharge_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(dram_ras_n) |-> (high_cnt >= T_RP));

   p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      ref_overrun |=> ref_overrun);

   p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      cpu_ready |=> !cpu_ready);
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.ROW_W(ROW_W), .T_RP(T_RP)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .dram_ras_n  (dram_ras_n),
   .dram_cas_n  (dram_cas_n),
   .dram_we_n   (dram_we_n),
   .dram_dq_oe  (dram_dq_oe),
   .cpu_ready   (cpu_ready),
   .ref_overrun (ref_overrun),
   .ref_row     (ref_row)
);

// File: tb/tb_dram_refresh_ctrl.sv
module dram_ctl_model #(
   parameter int ROW_W = 4, parameter int COL_W = 4, parameter int DATA_W = 8,
   parameter int RC = 40, parameter int T_RCD = 2, parameter int T_CAS = 2,
   parameter int T_RAS = 3, parameter int T_RP = 2, parameter int MA_W = 4
) (
   input  logic                    clk, rst, req, we,
   input  logic [ROW_W+COL_W-1:0]  addr,
   input  logic [DATA_W-1:0]       wdata, dq_in,
   output logic                    e_ras_n, e_cas_n, e_we_n, e_oe, e_ready, e_ovr,
   output logic [MA_W-1:0]         e_addr,
   output logic [DATA_W-1:0]       e_dq_out, e_rdata
);
   int mode, left, tcnt, rrow, lrow, lcol;
   bit pend, lwe;

   always @(posedge clk) begin
      if (rst) begin
         mode = 0; left = 0; tcnt = 0; rrow = 0; lrow = 0; lcol = 0;
         pend = 0; lwe = 0; e_ready = 0; e_rdata = '0; e_dq_out = '0; e_ovr = 0;
      end else begin
         bit dref, dacc, tk, pn;
         dref = (mode == 3 && left == 0);
         dacc = (mode == 2 && left == 0);
         tk   = (tcnt == RC - 1);
         tcnt = tk ? 0 : tcnt + 1;
         if (tk && pend && !dref) e_ovr = 1;
         pn = tk || (pend && !dref);
         e_ready = dacc;
         if (dacc) e_rdata = dq_in;
         if (dref) rrow = (rrow + 1) % (1 << ROW_W);
         case (mode)
            0: if (pend) begin mode = 3; left = T_RAS - 1; end
               else if (req) begin
                  lrow = int'(addr) >> COL_W; lcol = int'(addr) % (1 << COL_W);
                  lwe = we; e_dq_out = wdata; mode = 1; left = T_RCD - 1;
               end
            1: if (left == 0) begin mode = 2; left = T_CAS - 1; end else left--;
            2, 3: if (left == 0) begin mode = 4; left = T_RP - 1; end else left--;
            default: if (left == 0) mode = 0; else left--;
         endcase
         pend = pn;
      end
   end

   always_comb begin
      e_ras_n = !(mode == 1 || mode == 2 || mode == 3);
      e_cas_n = (mode != 2);
      e_we_n  = !(mode == 2 && lwe);
      e_oe    = (mode == 2 && lwe);
      e_addr  = (mode == 1) ? MA_W'(lrow) : (mode == 2) ? MA_W'(lcol) :
                (mode == 3) ? MA_W'(rrow) : '0;
   end
endmodule

module tb_dram_refresh_ctrl;
   localparam int ROW_W = 4, COL_W = 4, DATA_W = 8, RC = 40;
   localparam int T_RCD = 2, T_CAS = 2, T_RAS = 3, T_RP = 2;
   localparam int MA_W = 4, A_W = ROW_W + COL_W, NWORDS = 1 << A_W;

   logic clk = 0, rst = 1;
   always #2.5 clk = ~clk;

   logic              cpu_req = 0, cpu_we = 0, cpu_ready, ras_n, cas_n, we_n, oe, ovr;
   logic [A_W-1:0]    cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0, cpu_rdata, dq_out, dq_in;
   logic [MA_W-1:0]   maddr;

   dram_refresh_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REFRESH_CYCLES(RC),
      .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)) dut (
      .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .dram_addr(maddr), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
      .dram_dq_out(dq_out), .dram_dq_oe(oe), .dram_dq_in(dq_in), .ref_overrun(ovr));

   logic              o_ready, o_ras_n, o_cas_n, o_we_n, o_oe, o_ovr;
   logic [DATA_W-1:0] o_rdata, o_dq_out;
   logic [MA_W-1:0]   o_addr;

   dram_refresh_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REFRESH_CYCLES(4),
      .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)) dut_ovr (
      .clk(clk), .rst(rst), .cpu_req(1'b0), .cpu_we(1'b0), .cpu_addr('0),
      .cpu_wdata('0), .cpu_ready(o_ready), .cpu_rdata(o_rdata),
      .dram_addr(o_addr), .dram_ras_n(o_ras_n), .dram_cas_n(o_cas_n), .dram_we_n(o_we_n),
      .dram_dq_out(o_dq_out), .dram_dq_oe(o_oe), .dram_dq_in('0), .ref_overrun(o_ovr));

   logic              e_ras_n, e_cas_n, e_we_n, e_oe, e_ready, e_ovr;
   logic [MA_W-1:0]   e_addr;
   logic [DATA_W-1:0] e_dq_out, e_rdata;

   dram_ctl_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .RC(RC), .T_RCD(T_RCD),
      .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP), .MA_W(MA_W)) model (
      .clk(clk), .rst(rst), .req(cpu_req), .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata),
      .dq_in(dq_in), .e_ras_n(e_ras_n), .e_cas_n(e_cas_n), .e_we_n(e_we_n), .e_oe(e_oe),
      .e_ready(e_ready), .e_ovr(e_ovr), .e_addr(e_addr), .e_dq_out(e_dq_out), .e_rdata(e_rdata));

   // Array stand-in: row taken while RAS is low and CAS high, written on CAS with WE low.
   logic [DATA_W-1:0] mem [NWORDS];
   logic [DATA_W-1:0] shadow [NWORDS];
   logic [ROW_W-1:0]  row_l = '0;
   initial for (int i = 0; i < NWORDS; i++) begin
      mem[i] = DATA_W'(i * 7 + 3);
      shadow[i] = DATA_W'(i * 7 + 3);
   end
   always @(posedge clk) begin
      if (!ras_n && cas_n) row_l <= maddr[ROW_W-1:0];
      if (!cas_n && !we_n) mem[{row_l, maddr[COL_W-1:0]}] <= dq_out;
   end
   assign dq_in = mem[{row_l, maddr[COL_W-1:0]}];

   int n_checks = 0, n_fail = 0, cyc = 0;
   bit cmp_on = 0, finished = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison against the model.
   always @(negedge clk) if (cmp_on && !rst) begin
      check(ras_n == e_ras_n, "R8", "ras_n", ras_n, e_ras_n);
      check(cas_n == e_cas_n, "R2", "cas_n", cas_n, e_cas_n);
      if (!e_ras_n) check(maddr == e_addr, "R2", "dram_addr", maddr, e_addr);
      check(we_n == e_we_n, "R3", "we_n", we_n, e_we_n);
      check(oe == e_oe, "R3", "dq_oe", oe, e_oe);
      if (e_oe) check(dq_out == e_dq_out, "R3", "dq_out", dq_out, e_dq_out);
      check(cpu_ready == e_ready, "R10", "cpu_ready", cpu_ready, e_ready);
      if (e_ready) check(cpu_rdata == e_rdata, "R3", "cpu_rdata", cpu_rdata, e_rdata);
      check(ovr == e_ovr, "R9", "ref_overrun", ovr, e_ovr);
   end

   // Refresh detector: a RAS-low window with no CAS is a refresh.
   bit in_win = 0, saw_cas = 0, saw_drv = 0, wrapped = 0;
   int st_cyc = 0, st_row = 0, last_row = 0, last_start = 0, prev_start = 0, nref = 0;
   always @(negedge clk) if (!rst) begin
      if (!ras_n) begin
         if (!in_win) begin
            in_win = 1; saw_cas = 0; saw_drv = 0; st_cyc = cyc; st_row = int'(maddr);
         end
         if (!cas_n) saw_cas = 1;
         if (!we_n || oe) saw_drv = 1;
      end else if (in_win) begin
         in_win = 0;
         if (!saw_cas) begin
            check(!saw_drv, "R4", "refresh drove data or write enable", saw_drv, 0);
            check(cyc - st_cyc == T_RAS, "R4", "refresh RAS width", cyc - st_cyc, T_RAS);
            if (nref == 0)
               check(st_row == 0, "R5", "first refresh row", st_row, 0);
            else
               check(st_row == (last_row + 1) % (1 << ROW_W), "R5", "refresh row step",
                     st_row, (last_row + 1) % (1 << ROW_W));
            if (nref > 0 && last_row == (1 << ROW_W) - 1 && st_row == 0) wrapped = 1;
            last_row = st_row; prev_start = last_start; last_start = st_cyc; nref++;
         end
      end
   end

   task automatic access(input bit w, input logic [A_W-1:0] a, input logic [DATA_W-1:0] d);
      int waitc = 0;
      @(negedge clk);
      cpu_req = 1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
      do begin
         @(negedge clk);
         waitc++;
      end while (!cpu_ready && waitc < 100);
      check(cpu_ready, "R10", "ready within 100 cycles", cpu_ready, 1);
      if (w) shadow[a] = d;
      else check(cpu_rdata == shadow[a], "R3", "read-back data", cpu_rdata, shadow[a]);
      cpu_req = 0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(ras_n && cas_n && we_n, "R1", "strobes high in reset", {ras_n, cas_n, we_n}, 7);
      check(!oe && !cpu_ready && !ovr, "R1", "oe/ready/overrun low in reset",
            {oe, cpu_ready, ovr}, 0);
      rst = 0; cmp_on = 1;

      // Writes with distinct patterns, then read back.
      access(1, 8'h00, 8'hA5);
      access(1, 8'hFF, 8'h5A);
      access(1, 8'h3C, 8'hFF);
      access(1, 8'hC3, 8'h00);
      access(1, 8'h12, 8'h81);
      access(0, 8'h00, 0);
      access(0, 8'hFF, 0);
      access(0, 8'h3C, 0);
      access(0, 8'hC3, 0);
      access(0, 8'h12, 0);
      access(0, 8'h77, 0);

      // Idle: refreshes must start exactly one interval apart (R6).
      repeat (700) @(negedge clk);
      check(last_start - prev_start == RC, "R6", "idle refresh spacing",
            last_start - prev_start, RC);
      check(wrapped, "R5", "refresh row wrapped to 0", wrapped, 1);

      // Read issued as a refresh starts waits for it (R7).
      begin
         int k = 0;
         bit prev_hi = 1;
         do begin
            @(negedge clk);
            if (!(prev_hi && !ras_n)) prev_hi = ras_n;
            else break;
         end while (1);
         cpu_req = 1; cpu_we = 0; cpu_addr = 8'h3C;
         do begin
            @(negedge clk);
            k++;
         end while (!cpu_ready && k < 50);
         check(k == T_RAS + T_RP + 1 + T_RCD + T_CAS, "R7", "read latency behind refresh",
               k, T_RAS + T_RP + 1 + T_RCD + T_CAS);
         check(cpu_rdata == shadow[8'h3C], "R3", "read after refresh", cpu_rdata,
               shadow[8'h3C]);
         cpu_req = 0;
      end

      // Mixed traffic, back to back, crossing many refresh requests.
      for (int i = 0; i < 150; i++)
         access(1'($urandom % 2), A_W'($urandom), DATA_W'($urandom));

      check(!ovr, "R9", "no overrun with long interval", ovr, 0);
      check(o_ovr, "R9", "overrun with too-short interval", o_ovr, 1);
      check(o_cas_n && !o_ready, "R10", "refresh-only instance never strobes CAS/ready",
            {o_cas_n, o_ready}, 2);

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule